// File: doc/BRIEF.md
# Testable Carry-Select Lookahead Adder

This block adds two 64-bit operands and a carry-in in a single combinational pass and returns a 64-bit sum and a carry-out. Each operand bit pair feeds a bit cell that forms generate and propagate terms. A two-level lookahead tree merges these terms four at a time: bit pairs into 4-bit groups, and groups into 16-bit super-groups. A carry cell at each 8-bit boundary turns the merged prefix terms, together with the carry-in, into the carry for that boundary.

In parallel, every 8-bit slice computes two candidate results, one for an incoming carry of 0 and one for 1. Each candidate comes from a ripple chain of 2-bit add cells. The lookahead carry at the slice boundary then picks one candidate. Because the add cells and the lookahead tree are separate logic, a lookahead carry never has to ripple through the slice adders.

A single test input changes the bit cells and the carry cells so that every input combination of the lookahead cells can be applied from the operand pins. When the test input is 1, a bit cell passes operand A through as generate and operand B through as propagate. The carry cell always evaluates (G AND NOT P) OR (P AND carry-in). With the test input at 0, generate and propagate are never both 1, so this form gives the ordinary lookahead carry. The block is a drop-in adder for a datapath and holds no state, so it has no stream handshake.

Top module: `tsel_adder`

## Requirements
- R1: With test_en = 0, {cout, sum} equals the 65-bit sum of a, b and cin for every operand value.
- R2: cout is the carry into bit 64. All ones plus 1 gives sum 0 and cout 1, and all ones plus 0 with cin = 1 gives the same result.
- R3: With test_en = 0, a carry started at bit 0 travels through any number of low one-bits, across every 8-bit slice boundary, up to bit 64. For a = 2^k - 1 and b = 1, the sum is 2^k for every k from 0 to 64.
- R4: Sum bits below an 8-bit slice boundary depend only on the operand bits below that boundary and on cin. The carry that a slice's selected chain passes out equals the lookahead carry at the next boundary, and the carry into slice 0 is cin.
- R5: With test_en = 1 and a = 0, the result is still b + cin: sum = b + cin and cout = (all bits of b are 1) AND cin.
- R6: With test_en = 1, a all ones and b = 0, every bit cell generates without propagating, so every lookahead carry above slice 0 is 1. cout = 1, and sum is 0x00000000000000FF when cin = 0 and 0 when cin = 1.
- R7: With test_en = 1 and a = b = all ones, each bit cell both generates and propagates, so every lookahead carry equals cin. Each 8-bit slice of sum is 0xFE with its lowest bit replaced by cin, and cout = cin.
- R8: When test_en goes from 1 back to 0, the next result is the ordinary sum. For a = b = all ones and cin = 0, that is sum = 0xFFFFFFFFFFFFFFFE and cout = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| test_en | input | 1 | 1 switches the bit cells to pass-through generate/propagate for structural test |
| sum | output | 64 | Sum bits 63..0 |
| cout | output | 1 | Carry into bit 64, from the top of the lookahead tree |

## Verification
The bound checker watches the ports and the slice-level signals whenever they change. In normal mode it confirms that the result matches exact 65-bit arithmetic and that each slice's own chain carry agrees with the lookahead carry at the next boundary. It also confirms the three test-mode signatures, whether cin is 0 or 1. Only the bench's scenarios can show the ordered cases: a carry launched at bit 0 reaching every boundary, low slices staying unchanged while upper operand bits move, and a return from test mode. The bench's near-exhaustive sweep applies every pair of byte values, repeated across all eight slices, so every slice boundary sees every local carry pattern.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  // merge width of every lookahead node
  localparam int RADIX = 4;

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // neutral element of the generate/propagate merge
  localparam gp_t GP_IDENT = '{g: 1'b0, p: 1'b1};
endpackage

// File: rtl/tsel_bitcell.sv
module tsel_bitcell
  import tsel_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic test_en,
  output gp_t  gp_o
);
  always_comb begin
    if (test_en) begin
      gp_o.g = a_i;
      gp_o.p = b_i;
    end else begin
      gp_o.g = a_i & b_i;
      gp_o.p = a_i ^ b_i;
    end
  end
endmodule

// File: rtl/tsel_combine4.sv
module tsel_combine4
  import tsel_pkg::*;
(
  input  gp_t x3,  // most significant pair
  input  gp_t x2,
  input  gp_t x1,
  input  gp_t x0,  // least significant pair
  output gp_t y
);
  always_comb begin
    y.g = x3.g
        | (x3.p & x2.g)
        | (x3.p & x2.p & x1.g)
        | (x3.p & x2.p & x1.p & x0.g);
    y.p = x3.p & x2.p & x1.p & x0.p;
  end
endmodule

// File: rtl/tsel_carrycell.sv
module tsel_carrycell
  import tsel_pkg::*;
(
  input  gp_t  pre,
  input  logic cy_in,
  output logic cy_out
);
  // G AND NOT P keeps the cell's (1,1) input observable in test mode
  assign cy_out = (pre.g & ~pre.p) | (pre.p & cy_in);
endmodule

// File: rtl/tsel_add2.sv
module tsel_add2 (
  input  logic [1:0] a2,
  input  logic [1:0] b2,
  input  logic       ci,
  output logic [1:0] s2,
  output logic       co
);
  logic mid;
  always_comb begin
    s2[0] = a2[0] ^ b2[0] ^ ci;
    mid   = (a2[0] & b2[0]) | (ci & (a2[0] ^ b2[0]));
    s2[1] = a2[1] ^ b2[1] ^ mid;
    co    = (a2[1] & b2[1]) | (mid & (a2[1] ^ b2[1]));
  end
endmodule

// File: rtl/tsel_selblk.sv
module tsel_selblk #(
  parameter int BLK_W = 8
) (
  input  logic [BLK_W-1:0] a_blk,
  input  logic [BLK_W-1:0] b_blk,
  input  logic             sel,
  output logic [BLK_W-1:0] s_blk,
  output logic             cy_blk
);
  localparam int NCELL = BLK_W / 2;

  logic [1:0][NCELL:0]   ch;
  logic [1:0][BLK_W-1:0] cs;

  for (genvar c = 0; c < 2; c++) begin : g_chain
    assign ch[c][0] = (c == 1);
    for (genvar i = 0; i < NCELL; i++) begin : g_cell
      tsel_add2 u_add2 (
        .a2 (a_blk[2*i +: 2]),
        .b2 (b_blk[2*i +: 2]),
        .ci (ch[c][i]),
        .s2 (cs[c][2*i +: 2]),
        .co (ch[c][i+1])
      );
    end
  end

  assign s_blk  = sel ? cs[1] : cs[0];
  assign cy_blk = sel ? ch[1][NCELL] : ch[0][NCELL];
endmodule

// File: rtl/tsel_adder.sv
module tsel_adder #(
  parameter int WIDTH = 64,
  parameter int BLK_W = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic             test_en,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  import tsel_pkg::*;

  localparam int GRP_W = RADIX;
  localparam int SUP_W = RADIX * RADIX;
  localparam int NGRP  = WIDTH / GRP_W;
  localparam int NSUP  = WIDTH / SUP_W;
  localparam int NBLK  = WIDTH / BLK_W;

  gp_t bit_gp [WIDTH];
  gp_t grp_gp [NGRP];
  gp_t sup_gp [NSUP];
  gp_t sup_pre[NSUP+1];
  gp_t sp_in  [NSUP+1][RADIX];
  gp_t bd_in  [NBLK+1][RADIX];
  gp_t bd_pre [NBLK+1];

  logic [NBLK:0]   blk_c;
  logic [NBLK-1:0] blk_cy;

  // bit cells
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    tsel_bitcell u_bit (
      .a_i     (a[i]),
      .b_i     (b[i]),
      .test_en (test_en),
      .gp_o    (bit_gp[i])
    );
  end

  // level 1: 4-bit groups
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    tsel_combine4 u_c4 (
      .x3 (bit_gp[GRP_W*g+3]),
      .x2 (bit_gp[GRP_W*g+2]),
      .x1 (bit_gp[GRP_W*g+1]),
      .x0 (bit_gp[GRP_W*g]),
      .y  (grp_gp[g])
    );
  end

  // level 2: 16-bit super-groups
  for (genvar s = 0; s < NSUP; s++) begin : g_sup
    tsel_combine4 u_c4 (
      .x3 (grp_gp[RADIX*s+3]),
      .x2 (grp_gp[RADIX*s+2]),
      .x1 (grp_gp[RADIX*s+1]),
      .x0 (grp_gp[RADIX*s]),
      .y  (sup_gp[s])
    );
  end

  // prefix over super-groups 0..s-1
  for (genvar s = 0; s <= NSUP; s++) begin : g_spre
    for (genvar j = 0; j < RADIX; j++) begin : g_pos
      if (j < s) begin : g_use
        assign sp_in[s][j] = sup_gp[j];
      end else begin : g_pad
        assign sp_in[s][j] = GP_IDENT;
      end
    end
    tsel_combine4 u_c4 (
      .x3 (sp_in[s][3]),
      .x2 (sp_in[s][2]),
      .x1 (sp_in[s][1]),
      .x0 (sp_in[s][0]),
      .y  (sup_pre[s])
    );
  end

  // prefix and carry at each slice boundary
  for (genvar k = 0; k <= NBLK; k++) begin : g_bnd
    localparam int POS = k * BLK_W;
    localparam int SI  = POS / SUP_W;
    localparam int NG  = (POS % SUP_W) / GRP_W;
    assign bd_in[k][0] = sup_pre[SI];
    for (genvar j = 1; j < RADIX; j++) begin : g_pos
      if (j <= NG) begin : g_use
        assign bd_in[k][j] = grp_gp[SI*RADIX + j - 1];
      end else begin : g_pad
        assign bd_in[k][j] = GP_IDENT;
      end
    end
    tsel_combine4 u_c4 (
      .x3 (bd_in[k][3]),
      .x2 (bd_in[k][2]),
      .x1 (bd_in[k][1]),
      .x0 (bd_in[k][0]),
      .y  (bd_pre[k])
    );
    tsel_carrycell u_cy (
      .pre    (bd_pre[k]),
      .cy_in  (cin),
      .cy_out (blk_c[k])
    );
  end

  // carry-select slices
  for (genvar k = 0; k < NBLK; k++) begin : g_blk
    tsel_selblk #(.BLK_W(BLK_W)) u_blk (
      .a_blk  (a[k*BLK_W +: BLK_W]),
      .b_blk  (b[k*BLK_W +: BLK_W]),
      .sel    (blk_c[k]),
      .s_blk  (sum[k*BLK_W +: BLK_W]),
      .cy_blk (blk_cy[k])
    );
  end

  assign cout = blk_c[NBLK];
endmodule

// File: rtl/tsel_adder_chk.sv
module tsel_adder_chk #(
  parameter int WIDTH = 64,
  parameter int BLK_W = 8
) (
  input logic [WIDTH-1:0]         a,
  input logic [WIDTH-1:0]         b,
  input logic                     cin,
  input logic                     test_en,
  input logic [WIDTH-1:0]         sum,
  input logic                     cout,
  input logic [WIDTH/BLK_W:0]     blk_c,
  input logic [WIDTH/BLK_W-1:0]   blk_cy
);
  localparam int NBLK = WIDTH / BLK_W;

  logic [WIDTH:0]   exact;
  logic [WIDTH-1:0] r6_sum;
  logic [WIDTH-1:0] r7_sum;

  assign exact  = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
  assign r6_sum = cin ? '0 : {{(WIDTH-BLK_W){1'b0}}, {BLK_W{1'b1}}};
  assign r7_sum = {NBLK{{(BLK_W-1){1'b1}}, cin}};

  always_comb begin
    if (!test_en) begin
      p_sum_exact_r1: assert ({cout, sum} == exact)
        else $error("R1 sum mismatch");
      p_chain_vs_tree_r4: assert (blk_cy == blk_c[NBLK:1])
        else $error("R4 slice carry disagrees with lookahead");
      if (a == '1 && b == {{(WIDTH-1){1'b0}}, 1'b1} && !cin) begin
        p_wrap_r2: assert (sum == '0 && cout)
          else $error("R2 wrap");
      end
    end
    p_slice0_cin_r4: assert (blk_c[0] == cin)
      else $error("R4 slice 0 carry");
    if (test_en && a == '0) begin
      p_test_zero_a_r5: assert ({cout, sum} == exact)
        else $error("R5 test mode a=0");
    end
    if (test_en && a == '1 && b == '0) begin
      p_test_gen_r6: assert (cout && sum == r6_sum)
        else $error("R6 test mode generate-only");
    end
    if (test_en && a == '1 && b == '1) begin
      p_test_both_r7: assert (cout == cin && sum == r7_sum)
        else $error("R7 test mode generate and propagate");
    end
  end
endmodule

bind tsel_adder tsel_adder_chk #(.WIDTH(WIDTH), .BLK_W(BLK_W)) u_chk (
  .a       (a),
  .b       (b),
  .cin     (cin),
  .test_en (test_en),
  .sum     (sum),
  .cout    (cout),
  .blk_c   (blk_c),
  .blk_cy  (blk_cy)
);

// File: tb/tsel_adder_tb.sv
module tsel_adder_tb;
  localparam int W = 64;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [W-1:0] a, b, sum;
  logic cin, test_en, cout;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  tsel_adder u_dut (
    .a(a), .b(b), .cin(cin), .test_en(test_en), .sum(sum), .cout(cout)
  );

  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic cv, input logic tv);
    @(negedge clk);
    a = av; b = bv; cin = cv; test_en = tv;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_res(input string req, input logic [W-1:0] es,
                            input logic ec);
    checks++;
    if (sum !== es || cout !== ec) begin
      errors++;
      $display("FAIL %s: a=%h b=%h cin=%b test=%b got sum=%h cout=%b exp sum=%h cout=%b",
               req, a, b, cin, test_en, sum, cout, es, ec);
    end
  endtask

  task automatic add_check(input string req, input logic [W-1:0] av,
                           input logic [W-1:0] bv, input logic cv);
    logic [W:0] r;
    apply(av, bv, cv, 1'b0);
    r = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, cv};
    expect_res(req, r[W-1:0], r[W]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] base_s, x, y, m;
    logic [W:0] r;
    a = '0; b = '0; cin = 1'b0; test_en = 1'b0;

    // quiet start, R1
    apply('0, '0, 1'b0, 1'b0);
    expect_res("R1 zero", '0, 1'b0);

    // R2 carry into bit 64
    apply(ONES, 64'd1, 1'b0, 1'b0);
    expect_res("R2 ones+1", '0, 1'b1);
    apply(ONES, '0, 1'b1, 1'b0);
    expect_res("R2 ones+cin", '0, 1'b1);
    add_check("R2 ones+ones+cin", ONES, ONES, 1'b1);

    // R3 carry launched at bit 0 across every length
    for (int k = 0; k <= W; k++) begin
      m = (k == W) ? ONES : ((64'd1 << k) - 64'd1);
      add_check("R3 run", m, 64'd1, 1'b0);
      add_check("R3 run cin", m, '0, 1'b1);
    end

    // R4 low slices unaffected by upper operand bits
    for (int k = 1; k < 8; k++) begin
      for (int t = 0; t < 8; t++) begin
        x = {$urandom, $urandom};
        y = {$urandom, $urandom};
        m = (64'd1 << (8 * k)) - 64'd1;
        apply(x, y, t[0], 1'b0);
        base_s = sum;
        apply((x & m) | ({$urandom, $urandom} & ~m),
              (y & m) | ({$urandom, $urandom} & ~m), t[0], 1'b0);
        checks++;
        if ((sum & m) !== (base_s & m)) begin
          errors++;
          $display("FAIL R4 slice %0d: got %h exp %h", k, sum & m, base_s & m);
        end
      end
    end

    // R1 near-exhaustive: every byte pair replicated over all slices
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        add_check("R1 byte sweep", {8{i[7:0]}}, {8{j[7:0]}}, i[0] ^ j[0]);
      end
    end

    // R1 random operands
    for (int n = 0; n < 2000; n++)
      add_check("R1 random", {$urandom, $urandom}, {$urandom, $urandom}, n[0]);

    // R5 test mode, a = 0
    for (int n = 0; n < 40; n++) begin
      y = (n < 2) ? ONES : {$urandom, $urandom};
      apply('0, y, n[0] | (n == 1), 1'b1);
      r = {1'b0, y} + {{W{1'b0}}, cin};
      expect_res("R5 test a=0", r[W-1:0], (&y) & cin);
    end

    // R6 test mode, generate only
    apply(ONES, '0, 1'b0, 1'b1);
    expect_res("R6 test gen cin0", 64'h0000_0000_0000_00FF, 1'b1);
    apply(ONES, '0, 1'b1, 1'b1);
    expect_res("R6 test gen cin1", '0, 1'b1);

    // R7 test mode, generate and propagate
    apply(ONES, ONES, 1'b0, 1'b1);
    expect_res("R7 test both cin0", {8{8'hFE}}, 1'b0);
    apply(ONES, ONES, 1'b1, 1'b1);
    expect_res("R7 test both cin1", ONES, 1'b1);

    // R8 back to normal
    apply(ONES, ONES, 1'b0, 1'b0);
    expect_res("R8 normal again", 64'hFFFF_FFFF_FFFF_FFFE, 1'b1);
    apply(ONES, '0, 1'b0, 1'b0);
    expect_res("R8 normal ones+0", ONES, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule